// File: doc/BRIEF.md
# Dual 16-bit Signed Multiply-Accumulate Unit

This block is a datapath for a processor's execute stage. It takes two 32-bit operand words. Each word packs two signed 16-bit values, one in bits [15:0] and one in bits [31:16]. The unit forms both halfword products in the same cycle and combines them by addition or by subtraction. It then either returns that combined value on its own, adds it to a 32-bit accumulator, or adds it to a 64-bit accumulator supplied as one 64-bit input. It accepts a new operation on every clock cycle. The result appears one cycle after the operation is presented.

A second operand selector can swap the two halves of operand B before the multiply, which gives the cross products. In the 32-bit modes the result wraps modulo 2^32. Any result that does not fit in 32 bits as a signed value raises a sticky overflow flag. That flag stays set until an explicit clear input removes it.

Top module: `dual_mac16`

## Requirements
- R1: With mode 00, subtract 0 and exchange 0, the result is signed(A[15:0])*signed(B[15:0]) + signed(A[31:16])*signed(B[31:16]), taken modulo 2^32 on resLo.
- R2: With subtract 1, the high-half product is subtracted from the low-half product instead of added.
- R3: With exchange 1, B[31:16] and B[15:0] trade places before the multiply, giving A[15:0]*B[31:16] and A[31:16]*B[15:0].
- R4: Mode 00, and the spare code 11, return the combined products alone on resLo, with resHi equal to zero.
- R5: Mode 01 adds the combined products to accIn[31:0], taken as signed. The result wraps modulo 2^32 on resLo, and resHi is zero.
- R6: Mode 10 sign-extends the combined products to 64 bits and adds accIn[63:0], modulo 2^64. The upper word goes to resHi and the lower word to resLo.
- R7: Results are registered with one cycle of latency, and outValid equals inValid from the previous cycle. A new operation may be presented in every cycle.
- R8: While inValid is low, resLo and resHi keep their previous values.
- R9: A valid mode 00, 01 or 11 operation whose exact signed result lies outside [-2^31, 2^31-1] sets ovfSticky in the next cycle. Mode 10 never sets it.
- R10: ovfClear clears ovfSticky in the next cycle. If an overflowing operation arrives in the same cycle, the flag ends up set. Without either event the flag holds.
- R11: With all four halves at -32768 and the products added, mode 00 gives resLo 0x80000000 with overflow set. Mode 10 with a zero accumulator gives resHi 0 and resLo 0x80000000, with no overflow.
- R12: After reset, outValid, resLo, resHi and ovfSticky are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| opA | input | 32 | Packed signed halves of operand A |
| opB | input | 32 | Packed signed halves of operand B |
| accIn | input | 64 | Accumulator; bits [31:0] used in mode 01, all bits used in mode 10 |
| modeSel | input | 2 | 00 products only, 01 32-bit accumulate, 10 64-bit accumulate, 11 as 00 |
| subSel | input | 1 | 1 subtracts the high-half product from the low-half product |
| xchgSel | input | 1 | 1 swaps the halves of operand B |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| outValid | output | 1 | Result registers were loaded on the last edge |
| resLo | output | 32 | Result, lower word |
| resHi | output | 32 | Result, upper word (mode 10), else zero |
| ovfSticky | output | 1 | Sticky 32-bit overflow flag |

## Verification
The hardest situation to reach is the edge of the 32-bit range. An operation either just fits or just misses. This can happen in the middle of a sequence that is also clearing the sticky flag. Plain random 16-bit values almost never produce products near ±2^30 or an accumulator near ±2^31. The stimulus therefore draws each half from a biased set of -32768, 32767, -1 and random values. It draws the accumulator from a set that includes the 32-bit extremes. It also fires ovfClear on random cycles, so that clears sometimes coincide with overflowing operations. Directed steps cover the all -32768 case in both widths.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_ACC32 = 2'b01,
    MODE_ACC64 = 2'b10,
    MODE_SPARE = 2'b11
  } macMode_t;

  typedef struct packed {
    logic capture;
    logic accEn;
    logic wide;
    logic sub;
    logic xchg;
    logic ovfClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   modeSel,
  input  logic         subSel,
  input  logic         xchgSel,
  input  logic         ovfClear,
  output ctrlStrobes_t strb,
  output logic         outValid
);
  macMode_t mode;

  assign mode = macMode_t'(modeSel);

  always_comb begin
    strb         = '0;
    strb.capture = inValid;
    strb.sub     = subSel;
    strb.xchg    = xchgSel;
    strb.ovfClr  = ovfClear;
    unique case (mode)
      MODE_ACC32: strb.accEn = 1'b1;
      MODE_ACC64: begin
        strb.accEn = 1'b1;
        strb.wide  = 1'b1;
      end
      default: ;  // plain and spare codes: products only
    endcase
  end

  // R7: valid tracks the operation through the single result register stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/dmac_datapath.sv
module dmac_datapath
  import dmac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic [2*HALF_W-1:0]   opA,
  input  logic [2*HALF_W-1:0]   opB,
  input  logic [4*HALF_W-1:0]   accIn,
  output logic [2*HALF_W-1:0]   resLo,
  output logic [2*HALF_W-1:0]   resHi,
  output logic                  ovfSticky
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int ACC_W  = 2 * WORD_W;
  localparam int LANES  = 2;

  logic signed [WORD_W-1:0] prod [LANES];

  // R1 R3: one multiplier per lane; exchange picks the other half of B
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [HALF_W-1:0]        aHalf;
    logic [HALF_W-1:0]        bHalf;
    logic signed [WORD_W-1:0] aExt;
    logic signed [WORD_W-1:0] bExt;

    assign aHalf = opA[lane*HALF_W +: HALF_W];
    assign bHalf = strb.xchg ? opB[(LANES-1-lane)*HALF_W +: HALF_W]
                             : opB[lane*HALF_W +: HALF_W];
    assign aExt  = {{HALF_W{aHalf[HALF_W-1]}}, aHalf};
    assign bExt  = {{HALF_W{bHalf[HALF_W-1]}}, bHalf};
    assign prod[lane] = aExt * bExt;
  end

  logic signed [WORD_W:0] p0Ext;
  logic signed [WORD_W:0] p1Ext;
  logic signed [WORD_W:0] combined;
  logic [ACC_W-1:0]       accOp;
  logic [ACC_W-1:0]       total;
  logic                   fitsWord;
  logic                   ovfEvent;

  assign p0Ext    = {prod[0][WORD_W-1], prod[0]};
  assign p1Ext    = {prod[1][WORD_W-1], prod[1]};
  // R2: subtraction takes the high-half product away from the low-half one
  assign combined = strb.sub ? (p0Ext - p1Ext) : (p0Ext + p1Ext);

  always_comb begin
    if (!strb.accEn)    accOp = '0;
    else if (strb.wide) accOp = accIn;
    else                accOp = {{WORD_W{accIn[WORD_W-1]}}, accIn[WORD_W-1:0]};
  end

  assign total    = {{(ACC_W-WORD_W-1){combined[WORD_W]}}, combined} + accOp;
  assign fitsWord = (&total[ACC_W-1:WORD_W-1]) | ~(|total[ACC_W-1:WORD_W-1]);
  assign ovfEvent = strb.capture & ~strb.wide & ~fitsWord;

  // R4 R5 R6 R8: result registers load only on a valid operation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resLo <= '0;
      resHi <= '0;
    end else if (strb.capture) begin
      resLo <= total[WORD_W-1:0];
      resHi <= strb.wide ? total[ACC_W-1:WORD_W] : '0;
    end
  end

  // R9 R10: a new overflow wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ovfSticky <= 1'b0;
    else if (ovfEvent)    ovfSticky <= 1'b1;
    else if (strb.ovfClr) ovfSticky <= 1'b0;
  end
endmodule

// File: rtl/dual_mac16.sv
module dual_mac16
  import dmac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [2*HALF_W-1:0] opA,
  input  logic [2*HALF_W-1:0] opB,
  input  logic [4*HALF_W-1:0] accIn,
  input  logic [1:0]          modeSel,
  input  logic                subSel,
  input  logic                xchgSel,
  input  logic                ovfClear,
  output logic                outValid,
  output logic [2*HALF_W-1:0] resLo,
  output logic [2*HALF_W-1:0] resHi,
  output logic                ovfSticky
);
  ctrlStrobes_t strb;

  dmac_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modeSel  (modeSel),
    .subSel   (subSel),
    .xchgSel  (xchgSel),
    .ovfClear (ovfClear),
    .strb     (strb),
    .outValid (outValid)
  );

  dmac_datapath #(.HALF_W(HALF_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .accIn     (accIn),
    .resLo     (resLo),
    .resHi     (resHi),
    .ovfSticky (ovfSticky)
  );
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [1:0]          modeSel,
  input logic                ovfClear,
  input logic                outValid,
  input logic [2*HALF_W-1:0] resLo,
  input logic [2*HALF_W-1:0] resHi,
  input logic                ovfSticky
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R7
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(resLo) && $stable(resHi)));  // R8
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel != 2'b10) |=> (resHi == '0));  // R4
  AST_WIDE_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 2'b10 && !ovfClear) |=> (ovfSticky == $past(ovfSticky)));  // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfSticky && !ovfClear) |=> ovfSticky);  // R10
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClear && !inValid) |=> !ovfSticky);  // R10
endmodule

bind dual_mac16 dmac_checker #(.HALF_W(HALF_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .modeSel   (modeSel),
  .ovfClear  (ovfClear),
  .outValid  (outValid),
  .resLo     (resLo),
  .resHi     (resHi),
  .ovfSticky (ovfSticky)
);

// File: tb/test_dual_mac16.sv
`timescale 1ns/1ps
module test_dual_mac16;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [63:0] accIn = '0;
  logic [1:0]  modeSel = '0;
  logic        subSel = 1'b0;
  logic        xchgSel = 1'b0;
  logic        ovfClear = 1'b0;
  logic        outValid;
  logic [31:0] resLo;
  logic [31:0] resHi;
  logic        ovfSticky;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  bit          expValid = 1'b0;
  logic [31:0] expLo = '0;
  logic [31:0] expHi = '0;
  bit          expOvf = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_mac16 i_dual_mac16 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .accIn(accIn), .modeSel(modeSel), .subSel(subSel), .xchgSel(xchgSel),
    .ovfClear(ovfClear), .outValid(outValid), .resLo(resLo), .resHi(resHi),
    .ovfSticky(ovfSticky)
  );

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    cmp("R7", "outValid", longint'(outValid), longint'(expValid));
    cmp(tag, "resLo", longint'(resLo), longint'(expLo));
    cmp(tag, "resHi", longint'(resHi), longint'(expHi));
    cmp((tag == "R11") ? "R11" : "R9 R10", "ovfSticky", longint'(ovfSticky), longint'(expOvf));
  endtask

  function automatic longint sx16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  // behavioural model of one operation, applied to the reference state
  task automatic modelStep(input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                           input logic [1:0] mode, input bit sub, input bit xchg,
                           input bit clr, input bit vld);
    longint bLow, bHigh, lowProd, highProd, comb, t;
    bit overflow = 1'b0;
    bLow  = xchg ? sx16(b[31:16]) : sx16(b[15:0]);
    bHigh = xchg ? sx16(b[15:0])  : sx16(b[31:16]);
    lowProd  = sx16(a[15:0]) * bLow;
    highProd = sx16(a[31:16]) * bHigh;
    comb = sub ? lowProd - highProd : lowProd + highProd;
    expValid = vld;
    if (vld) begin
      if (mode == 2'b10) begin
        t = comb + longint'(acc);
        expLo = t[31:0];
        expHi = t[63:32];
      end else begin
        t = (mode == 2'b01) ? comb + longint'($signed(acc[31:0])) : comb;
        overflow = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        expLo = t[31:0];
        expHi = '0;
      end
    end
    if (overflow) expOvf = 1'b1;
    else if (clr) expOvf = 1'b0;
  endtask

  // called at a falling edge: drive, update model, wait one cycle, compare
  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                      input logic [1:0] mode, input bit sub, input bit xchg,
                      input bit clr, input bit vld, input string tag);
    opA = a; opB = b; accIn = acc; modeSel = mode; subSel = sub;
    xchgSel = xchg; ovfClear = clr; inValid = vld;
    modelStep(a, b, acc, mode, sub, xchg, clr, vld);
    @(negedge clk);
    compareAll(tag);
  endtask

  function automatic logic [15:0] pickHalf();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [63:0] pickAcc();
    case ($urandom_range(0, 5))
      0: return 64'h0000_0000_7FFF_FFF0;
      1: return 64'hFFFF_FFFF_8000_0010;
      2: return 64'h7FFF_FFFF_FFFF_FFF0;
      default: return {32'($urandom), 32'($urandom)};
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R12");  // reset state
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R12");

    step(32'h0003_0002, 32'h0005_0004, 64'h0, 2'b00, 0, 0, 0, 1, "R1");   // 23
    step(32'hFFFD_0002, 32'h0005_FFFC, 64'h0, 2'b00, 0, 0, 0, 1, "R1");   // -8 + -15
    step(32'h0003_0002, 32'h0005_FFFC, 64'h0, 2'b00, 1, 0, 0, 1, "R2");   // -8 - 15
    step(32'h0003_0002, 32'h0005_0004, 64'h0, 2'b00, 0, 1, 0, 1, "R3");   // 10 + 12
    step(32'h0003_0002, 32'h0005_0004, 64'h0, 2'b00, 1, 1, 0, 1, "R3");
    step(32'h0003_0002, 32'h0005_0004, 64'hFFFF_0000_0000_0100, 2'b11, 0, 0, 0, 1, "R4");
    step(32'h0003_0002, 32'h0005_0004, 64'hFFFF_0000_0000_0100, 2'b01, 0, 0, 0, 1, "R5");
    step(32'h0003_0002, 32'h0005_0004, 64'h0000_0000_7FFF_FFFF, 2'b01, 0, 0, 0, 1, "R5");  // wraps, sets flag
    step(32'h0, 32'h0, 64'h0, 2'b00, 0, 0, 0, 0, "R8");                   // idle: hold
    step(32'h1234_5678, 32'h1111_2222, 64'h5, 2'b01, 0, 0, 0, 0, "R8");
    step(32'h0, 32'h0, 64'h0, 2'b00, 0, 0, 1, 0, "R10");                  // clear alone
    step(32'h8000_8000, 32'h8000_8000, 64'h0, 2'b00, 0, 0, 1, 1, "R11"); // set beats clear
    step(32'h8000_8000, 32'h8000_8000, 64'h0, 2'b00, 0, 0, 1, 0, "R10");
    step(32'h8000_8000, 32'h8000_8000, 64'h0, 2'b10, 0, 0, 0, 1, "R11"); // +2^31, no flag
    step(32'h8000_8000, 32'h8000_8000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 0, 0, 0, 1, "R6");
    step(32'h7FFF_8000, 32'h8000_7FFF, 64'h8000_0000_0000_0000, 2'b10, 1, 0, 0, 1, "R6");
    step(32'h8000_8000, 32'h8000_8000, 64'h0, 2'b10, 1, 0, 0, 1, "R9");  // wide: flag untouched
    step(32'h7FFF_7FFF, 32'h7FFF_7FFF, 64'h0000_0000_0000_0001, 2'b01, 0, 0, 0, 1, "R5");
    step(32'h7FFF_7FFF, 32'h7FFF_7FFF, 64'h0, 2'b00, 0, 0, 0, 1, "R7");  // back to back
    step(32'h0001_0001, 32'h0001_0001, 64'h0, 2'b00, 0, 0, 1, 1, "R7");

    for (int i = 0; i < 3000; i++) begin
      step({pickHalf(), pickHalf()}, {pickHalf(), pickHalf()}, pickAcc(),
           2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 4) != 0), "R6 R5 R1");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule